// File: doc/BRIEF.md
# Floating-Point Significand Divider with Directed Rounding

This block divides one binary floating-point value by another. Each operand arrives already unpacked as a sign bit, an 8-bit exponent stored with a bias of 127, and a 24-bit significand whose leading one is explicit. Every operand is assumed normalized. A one-cycle `start` pulse captures both operands and a 2-bit rounding selection. The block then produces one quotient bit per clock by restoring division and pulses `done` when the registered result is ready.

The significand quotient of two normalized operands lies in [0.5, 2). A single optional left shift therefore normalizes it, and that shift lowers the exponent by one. The rounding stage uses a guard bit and a sticky bit to apply one of four modes: nearest-even, toward zero, toward plus infinity and toward minus infinity. Three conditions are flagged: a zero divisor, exponent overflow and exponent underflow.

Top module: `fpdiv_unit`

## Requirements
- R1: While reset is high and on the first cycle after it falls, `busy`, `done`, all three flags and every result output are 0.
- R2: When the block is idle, `start` is accepted on a rising edge. `busy` is then high from the next cycle until the result is ready. `done` is high for exactly one cycle, which begins at the 27th rising edge after the accepting edge, and `busy` is low in that cycle. A `start` pulse that arrives while `busy` is high has no effect: the result and its timing still belong to the accepted operands, and no further `done` follows.
- R3: The result sign is the XOR of the operand signs, in every case including the flagged ones.
- R4: For a regular result, the significand is the rounded quotient a_man/b_man, normalized so that bit 23 is 1. The exponent is a_exp − b_exp + 127 when a_man ≥ b_man. Otherwise the quotient is shifted left once and the exponent is a_exp − b_exp + 126.
- R5: `rnd_mode` selects the rounding: 00 nearest with ties to even, 01 toward zero, 10 toward plus infinity, 11 toward minus infinity. The rounding uses the bit below the result LSB (guard) and the OR of every lower quotient bit and the final remainder (sticky). If rounding carries out of the significand, the significand becomes 0x800000 and the exponent goes up by one.
- R6: A divisor with b_exp = 0 is treated as zero. It sets `div_zero`, returns exponent 255 with significand 0, and clears the other flags. This case takes priority over a zero dividend.
- R7: A dividend with a_exp = 0 and a non-zero divisor returns exponent 0 and significand 0, with no flag set.
- R8: If the exponent after rounding exceeds 254, `overflow` is set and the result has exponent 255 and significand 0. An exponent of exactly 254 is a regular result.
- R9: If the exponent after rounding is below 1, `underflow` is set and the result has exponent 0 and significand 0. An exponent of exactly 1 is a regular result.
- R10: The result outputs and flags change only at the edge that raises `done`. They hold their values at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a division; honoured only when idle |
| a_sign | input | 1 | Dividend sign |
| a_exp | input | 8 | Dividend biased exponent |
| a_man | input | 24 | Dividend significand with explicit leading one |
| b_sign | input | 1 | Divisor sign |
| b_exp | input | 8 | Divisor biased exponent (0 means zero divisor) |
| b_man | input | 24 | Divisor significand with explicit leading one |
| rnd_mode | input | 2 | Rounding selection (encoding in R5) |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse; result outputs are valid |
| q_sign | output | 1 | Result sign |
| q_exp | output | 8 | Result biased exponent |
| q_man | output | 24 | Result significand |
| div_zero | output | 1 | Divisor was zero |
| overflow | output | 1 | Result exponent above 254 |
| underflow | output | 1 | Result exponent below 1 |

## Verification
A wrong partial remainder or a lost quotient bit is not visible while the division runs. It first shows in the `done` cycle, 27 edges after acceptance, as a wrong significand, a wrong guard or sticky bit, or, when the top quotient bit is wrong, an exponent that is off by one. A sequencer count error shows as `done` arriving on the wrong edge, and the bench measures that edge for every operation. The sweep drives every rounding mode and every sign combination across a large set of significand pairs, so that an error in the sticky bit or in the choice of shift produces a result mismatch on the first affected operation.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;
    localparam int EXP_W   = 8;
    localparam int MAN_W   = 24;
    localparam int QUO_W   = MAN_W + 2;
    localparam int REM_W   = MAN_W + 1;
    localparam int EXS_W   = EXP_W + 2;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_TOP = (1 << EXP_W) - 1;
    localparam int CNT_W   = $clog2(QUO_W);

    typedef logic signed [EXS_W-1:0] sexp_t;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_ZERO      = 2'b01,
        RM_UP        = 2'b10,
        RM_DOWN      = 2'b11
    } rmode_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } fp_t;

    typedef struct packed {
        fp_t  val;
        logic dz;
        logic ovf;
        logic unf;
    } fpres_t;

    function automatic logic round_up(input rmode_e mode, input logic sign,
                                      input logic lsb, input logic grd,
                                      input logic stk);
        logic r;
        case (mode)
            RM_NEAR_EVEN: r = grd & (stk | lsb);
            RM_ZERO:      r = 1'b0;
            RM_UP:        r = ~sign & (grd | stk);
            RM_DOWN:      r = sign & (grd | stk);
            default:      r = 1'b0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/fpdiv_seq.sv
module fpdiv_seq
    import fpdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic finish,
    output logic busy
);
    typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_e;

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(QUO_W - 1);

    st_e              st_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    if (start) begin
                        st_q  <= S_RUN;
                        cnt_q <= '0;
                    end
                end
                S_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST_BIT) st_q <= S_FIN;
                end
                S_FIN:   st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign load   = (st_q == S_IDLE) && start;
    assign step   = (st_q == S_RUN);
    assign finish = (st_q == S_FIN);
    assign busy   = (st_q != S_IDLE);
endmodule

// File: rtl/fpdiv_iter.sv
module fpdiv_iter
    import fpdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [MAN_W-1:0] num,
    input  logic [MAN_W-1:0] den,
    output logic [QUO_W-1:0] quo,
    output logic             rem_nz
);
    logic [REM_W-1:0] rem_q;
    logic [MAN_W-1:0] den_q;
    logic [QUO_W-1:0] quo_q;
    logic [REM_W-1:0] trial;
    logic             fits;

    always_comb begin
        fits  = rem_q >= {1'b0, den_q};
        trial = fits ? (rem_q - {1'b0, den_q}) : rem_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            den_q <= '0;
            quo_q <= '0;
        end else if (load) begin
            rem_q <= {1'b0, num};
            den_q <= den;
            quo_q <= '0;
        end else if (step) begin
            rem_q <= {trial[REM_W-2:0], 1'b0};
            quo_q <= {quo_q[QUO_W-2:0], fits};
        end
    end

    assign quo    = quo_q;
    assign rem_nz = |rem_q;
endmodule

// File: rtl/fpdiv_post.sv
module fpdiv_post
    import fpdiv_pkg::*;
(
    input  logic [QUO_W-1:0] quo,
    input  logic             rem_nz,
    input  logic             sign,
    input  sexp_t            exp_base,
    input  rmode_e           rmode,
    input  logic             dz,
    input  logic             zero_num,
    output fpres_t           res
);
    logic [MAN_W-1:0] man_t;
    logic [MAN_W-1:0] man_f;
    logic [MAN_W:0]   man_r;
    logic             grd;
    logic             stk;
    logic             inc;
    sexp_t            exp_n;
    sexp_t            exp_r;

    always_comb begin
        if (quo[QUO_W-1]) begin
            man_t = quo[QUO_W-1 -: MAN_W];
            grd   = quo[1];
            stk   = quo[0] | rem_nz;
            exp_n = exp_base;
        end else begin
            man_t = quo[QUO_W-2 -: MAN_W];
            grd   = quo[0];
            stk   = rem_nz;
            exp_n = exp_base - sexp_t'(1);
        end

        inc   = round_up(rmode, sign, man_t[0], grd, stk);
        man_r = {1'b0, man_t} + {{MAN_W{1'b0}}, inc};
        man_f = man_r[MAN_W-1:0];
        exp_r = exp_n;
        if (man_r[MAN_W]) begin
            man_f = man_r[MAN_W:1];
            exp_r = exp_n + sexp_t'(1);
        end

        res          = '0;
        res.val.sign = sign;
        if (dz) begin
            res.dz      = 1'b1;
            res.val.exp = EXP_W'(EXP_TOP);
        end else if (zero_num) begin
            res.val.exp = '0;
        end else if (exp_r > sexp_t'(EXP_TOP - 1)) begin
            res.ovf     = 1'b1;
            res.val.exp = EXP_W'(EXP_TOP);
        end else if (exp_r < sexp_t'(1)) begin
            res.unf     = 1'b1;
        end else begin
            res.val.exp = exp_r[EXP_W-1:0];
            res.val.man = man_f;
        end
    end
endmodule

// File: rtl/fpdiv_unit.sv
module fpdiv_unit
    import fpdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             a_sign,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [MAN_W-1:0] a_man,
    input  logic             b_sign,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [MAN_W-1:0] b_man,
    input  logic [1:0]       rnd_mode,
    output logic             busy,
    output logic             done,
    output logic             q_sign,
    output logic [EXP_W-1:0] q_exp,
    output logic [MAN_W-1:0] q_man,
    output logic             div_zero,
    output logic             overflow,
    output logic             underflow
);
    logic             load;
    logic             step;
    logic             finish;
    logic [QUO_W-1:0] quo;
    logic             rem_nz;

    logic   sign_q;
    sexp_t  exp_base_q;
    rmode_e rmode_q;
    logic   dz_q;
    logic   zn_q;
    fpres_t post_res;
    fpres_t res_q;
    logic   done_q;

    fpdiv_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .load   (load),
        .step   (step),
        .finish (finish),
        .busy   (busy)
    );

    fpdiv_iter u_iter (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .step   (step),
        .num    (a_man),
        .den    (b_man),
        .quo    (quo),
        .rem_nz (rem_nz)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sign_q     <= 1'b0;
            exp_base_q <= '0;
            rmode_q    <= RM_NEAR_EVEN;
            dz_q       <= 1'b0;
            zn_q       <= 1'b0;
        end else if (load) begin
            sign_q     <= a_sign ^ b_sign;
            exp_base_q <= sexp_t'({2'b00, a_exp}) - sexp_t'({2'b00, b_exp})
                          + sexp_t'(BIAS);
            rmode_q    <= rmode_e'(rnd_mode);
            dz_q       <= (b_exp == '0);
            zn_q       <= (a_exp == '0);
        end
    end

    fpdiv_post u_post (
        .quo      (quo),
        .rem_nz   (rem_nz),
        .sign     (sign_q),
        .exp_base (exp_base_q),
        .rmode    (rmode_q),
        .dz       (dz_q),
        .zero_num (zn_q),
        .res      (post_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) res_q <= post_res;
        end
    end

    assign done      = done_q;
    assign q_sign    = res_q.val.sign;
    assign q_exp     = res_q.val.exp;
    assign q_man     = res_q.val.man;
    assign div_zero  = res_q.dz;
    assign overflow  = res_q.ovf;
    assign underflow = res_q.unf;
endmodule

// File: rtl/fpdiv_unit_chk.sv
module fpdiv_unit_chk
    import fpdiv_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             q_sign,
    input logic [EXP_W-1:0] q_exp,
    input logic [MAN_W-1:0] q_man,
    input logic             div_zero,
    input logic             overflow,
    input logic             underflow
);
    logic [7:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst)       busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 8'd1;
        else           busy_cnt <= '0;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R2
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R2
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy_cnt == 8'(QUO_W + 1))); // R2
    AST_NORMALIZED: assert property (@(posedge clk) disable iff (rst)
        (done && !div_zero && !overflow && !underflow && q_exp != '0)
        |-> q_man[MAN_W-1]); // R4
    AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        done |-> $onehot0({div_zero, overflow, underflow})); // R6
    AST_DZ_RESULT: assert property (@(posedge clk) disable iff (rst)
        (done && div_zero) |-> (q_exp == '1 && q_man == '0)); // R6
    AST_OVF_RESULT: assert property (@(posedge clk) disable iff (rst)
        (done && overflow) |-> (q_exp == '1 && q_man == '0)); // R8
    AST_UNF_RESULT: assert property (@(posedge clk) disable iff (rst)
        (done && underflow) |-> (q_exp == '0 && q_man == '0)); // R9
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({q_sign, q_exp, q_man, div_zero, overflow, underflow})); // R10
endmodule

bind fpdiv_unit fpdiv_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .q_sign    (q_sign),
    .q_exp     (q_exp),
    .q_man     (q_man),
    .div_zero  (div_zero),
    .overflow  (overflow),
    .underflow (underflow)
);

// File: tb/fpdiv_unit_bench.sv
module fpdiv_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        a_sign = 1'b0, b_sign = 1'b0;
    logic [7:0]  a_exp = '0, b_exp = '0;
    logic [23:0] a_man = '0, b_man = '0;
    logic [1:0]  rnd_mode = '0;
    logic        busy, done, q_sign, div_zero, overflow, underflow;
    logic [7:0]  q_exp;
    logic [23:0] q_man;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fpdiv_unit u_fpdiv_unit (
        .clk(clk), .rst(rst), .start(start),
        .a_sign(a_sign), .a_exp(a_exp), .a_man(a_man),
        .b_sign(b_sign), .b_exp(b_exp), .b_man(b_man),
        .rnd_mode(rnd_mode), .busy(busy), .done(done),
        .q_sign(q_sign), .q_exp(q_exp), .q_man(q_man),
        .div_zero(div_zero), .overflow(overflow), .underflow(underflow)
    );

    function automatic logic [35:0] got();
        return {q_sign, q_exp, q_man, div_zero, overflow, underflow};
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Expected result from the arithmetic in R3..R9
    function automatic logic [35:0] model(input logic as, input logic [7:0] ae,
                                          input logic [23:0] am, input logic bs,
                                          input logic [7:0] be, input logic [23:0] bm,
                                          input logic [1:0] rm);
        longint num, q, r, e, mm;
        logic [23:0] man;
        logic g, s, inc, sg;
        sg = as ^ bs;
        if (be == 8'd0) return {sg, 8'hFF, 24'h0, 3'b100};
        if (ae == 8'd0) return {sg, 8'h00, 24'h0, 3'b000};
        num = longint'(am) << 25;
        q = num / longint'(bm);
        r = num % longint'(bm);
        e = longint'(ae) - longint'(be) + 127;
        if (q[25]) begin
            man = 24'(q >> 2); g = q[1]; s = q[0] | (r != 0);
        end else begin
            man = 24'(q >> 1); g = q[0]; s = (r != 0); e = e - 1;
        end
        case (rm)
            2'b00:   inc = g & (s | man[0]);
            2'b01:   inc = 1'b0;
            2'b10:   inc = ~sg & (g | s);
            default: inc = sg & (g | s);
        endcase
        mm = longint'(man) + longint'(inc);
        if (mm == (longint'(1) << 24)) begin
            man = 24'h800000; e = e + 1;
        end else begin
            man = 24'(mm);
        end
        if (e > 254) return {sg, 8'hFF, 24'h0, 3'b010};
        if (e < 1)   return {sg, 8'h00, 24'h0, 3'b001};
        return {sg, 8'(e), man, 3'b000};
    endfunction

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_op(input logic as, input logic [7:0] ae, input logic [23:0] am,
                          input logic bs, input logic [7:0] be, input logic [23:0] bm,
                          input logic [1:0] rm, input string tag);
        logic [35:0] expv;
        int lat;
        expv = model(as, ae, am, bs, be, bm, rm);
        @(negedge clk);
        a_sign = as; a_exp = ae; a_man = am;
        b_sign = bs; b_exp = be; b_man = bm;
        rnd_mode = rm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(lat);
        chk(lat == 27, "R2 done latency", 64'(lat), 64'd27);
        chk(got() == expv, tag, 64'(got()), 64'(expv));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL R2 watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] lcg;
        logic [35:0] held;
        logic [35:0] expa;
        int lat;
        int extra;

        repeat (3) @(posedge clk);
        chk({busy, done, got()} == 38'd0, "R1 state during reset",
            64'({busy, done, got()}), 64'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({busy, done, got()} == 38'd0, "R1 state after reset",
            64'({busy, done, got()}), 64'd0);

        // Sweep: all modes, all sign pairs, many significand pairs (R3 R4 R5)
        lcg = 32'h1234_5678;
        for (int i = 0; i < 40; i++) begin
            logic [23:0] ma, mb;
            logic [7:0] ea, eb;
            case (i)
                0: begin ma = 24'h800000; mb = 24'h800000; end
                1: begin ma = 24'hFFFFFF; mb = 24'h800000; end
                2: begin ma = 24'h800000; mb = 24'hFFFFFF; end
                3: begin ma = 24'hFFFFFE; mb = 24'hFFFFFF; end
                4: begin ma = 24'hFFFFFF; mb = 24'hFFFFFE; end
                5: begin ma = 24'hC00000; mb = 24'hA00000; end
                default: begin
                    lcg = lcg * 32'd1664525 + 32'd1013904223;
                    ma  = 24'h800000 | lcg[30:8];
                    lcg = lcg * 32'd1664525 + 32'd1013904223;
                    mb  = 24'h800000 | lcg[30:8];
                end
            endcase
            ea = 8'(100 + i % 50);
            eb = 8'(90 + i % 40);
            for (int m = 0; m < 4; m++)
                for (int sp = 0; sp < 4; sp++)
                    run_op(sp[1], ea, ma, sp[0], eb, mb, 2'(m), "R3 R4 R5 sweep result");
        end

        // Zero divisor and zero dividend (R6 R7)
        run_op(1'b1, 8'd130, 24'h900000, 1'b0, 8'd0, 24'h800000, 2'b00, "R6 zero divisor");
        run_op(1'b0, 8'd0, 24'h800000, 1'b1, 8'd0, 24'h800000, 2'b10, "R6 zero over zero");
        run_op(1'b0, 8'd0, 24'h800000, 1'b1, 8'd120, 24'hA00000, 2'b00, "R7 zero dividend");

        // Exponent boundaries (R8 R9)
        run_op(1'b0, 8'd254, 24'hC00000, 1'b0, 8'd1, 24'h800000, 2'b00, "R8 overflow");
        run_op(1'b0, 8'd254, 24'hC00000, 1'b1, 8'd127, 24'h800000, 2'b01, "R8 exp 254 no overflow");
        run_op(1'b0, 8'd254, 24'h800000, 1'b0, 8'd126, 24'hC00000, 2'b00, "R8 exp 254 after shift");
        run_op(1'b0, 8'd254, 24'hC00000, 1'b0, 8'd126, 24'h800000, 2'b00, "R8 exp 255 overflow");
        run_op(1'b1, 8'd1, 24'h800000, 1'b0, 8'd254, 24'hC00000, 2'b11, "R9 underflow");
        run_op(1'b0, 8'd1, 24'h900000, 1'b0, 8'd127, 24'hA00000, 2'b00, "R9 exp 0 underflow");
        run_op(1'b0, 8'd1, 24'hA00000, 1'b0, 8'd127, 24'h900000, 2'b10, "R9 exp 1 regular");

        // Start while busy is ignored (R2), outputs hold (R10)
        expa = model(1'b0, 8'd140, 24'hB00000, 1'b1, 8'd120, 24'hD00000, 2'b10);
        @(negedge clk);
        a_sign = 1'b0; a_exp = 8'd140; a_man = 24'hB00000;
        b_sign = 1'b1; b_exp = 8'd120; b_man = 24'hD00000;
        rnd_mode = 2'b10; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after accept", 64'(busy), 64'd1);
        repeat (5) @(negedge clk);
        a_sign = 1'b1; a_exp = 8'd0; b_exp = 8'd0; rnd_mode = 2'b01; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(lat);
        chk(lat == 21, "R2 latency with ignored start", 64'(lat), 64'd21);
        chk(got() == expa, "R2 ignored start result", 64'(got()), 64'(expa));
        held = got();
        extra = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (done) extra++;
            if (got() != held) extra += 100;
        end
        chk(extra == 0, "R2 R10 no extra done, outputs held", 64'(extra), 64'd0);
        chk(busy == 1'b0, "R2 idle after ignored start", 64'(busy), 64'd0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule